// File: doc/BRIEF.md
# Bus Hold Arbiter with Refresh Preemption

This block decides who drives the local bus: the local processor or an external bus master. The master asks for the bus on an asynchronous request line. The arbiter synchronizes that line and grants the bus only when the processor's bus sequencer reports a cycle boundary (the end of the last cycle state, or an idle state). A grant raises the acknowledge output and the float enable together. The float enable tristates the address/data bus and the strobes. Chip selects are never floated.

When a DRAM refresh becomes due while the master owns the bus, the enhanced mode lets the arbiter take the bus back. It drops the acknowledge while the bus is still floated. It then waits for the master to withdraw its request, hands the bus to the sequencer for one refresh cycle, and re-grants the master as soon as the refresh completes. In compatible mode a pending refresh waits until the master releases the bus of its own accord.

A small latch keeps the externally visible latched address bits at their last value while the bus is floated.

Top module: `bus_yield_arbiter`

## Requirements
- R1: The request input passes through SYNC_STAGES (default 2) flip-flops. With the bus idle and the boundary flag high, hold_ack rises on the third clock edge after the request goes high.
- R2: hold_ack rises only on an edge where seq_boundary or refresh_done was high in the cycle before. It never rises in the middle of a bus cycle.
- R3: hold_ack and bus_float rise on the same edge. hold_ack is never high while bus_float is low.
- R4: After the synchronized request is seen low, hold_ack and bus_float fall together on the third edge after the request input falls.
- R5: In enhanced mode (enhanced_mode=1), a refresh pending while the bus is granted drops hold_ack on the next edge, while bus_float stays high. This state lasts for as long as the synchronized request stays high.
- R6: Once the request is seen low in that state, refresh_grant goes high and bus_float goes low. If refresh_done is high while the synchronized request is high, hold_ack and bus_float return on the next edge and refresh_grant falls.
- R7: In compatible mode (enhanced_mode=0), a pending refresh never drops hold_ack. The refresh is granted only at the first cycle boundary after the bus is released.
- R8: While the processor owns the bus at a cycle boundary, a pending refresh is granted ahead of a pending hold request.
- R9: lat_addr_q loads addr_in on an edge where addr_load is high and bus_float is low. While bus_float is high, lat_addr_q keeps its value.
- R10: After reset, hold_ack, bus_float, refresh_grant and lat_addr_q are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Asynchronous bus request from the external master |
| seq_boundary | input | 1 | Sequencer is at the end of the last cycle state or idle |
| refresh_pending | input | 1 | A DRAM refresh is due |
| enhanced_mode | input | 1 | 1 selects enhanced mode (refresh preemption) |
| refresh_done | input | 1 | The granted refresh cycle completes in this cycle |
| addr_load | input | 1 | Capture addr_in into the address latch |
| addr_in | input | ADDR_W | Address bits to be latched |
| hold_ack | output | 1 | Bus granted to the external master |
| bus_float | output | 1 | Tristate enable for the bus and strobes |
| refresh_grant | output | 1 | Sequencer may run the refresh cycle now |
| lat_addr_q | output | ADDR_W | Latched address bits, held during float |

## Verification
A wrong arbiter state shows at the ports within one clock. If the reclaim state is lost, hold_ack stays high while a refresh is pending. If the refresh state is lost, refresh_grant never appears, or it appears while bus_float is still high. A synchronizer of the wrong depth shifts the grant and release edges by whole cycles, so the bench samples each transition at its exact edge count. It also walks the drop, refresh and regrant sequence one cycle at a time.

// File: rtl/bya_pkg.sv
package bya_pkg;
  typedef enum logic [1:0] {
    ST_OWN     = 2'd0,
    ST_GRANT   = 2'd1,
    ST_RECLAIM = 2'd2,
    ST_REFRESH = 2'd3
  } arb_state_t;
endpackage

// File: rtl/bya_sync.sv
module bya_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/bya_fsm.sv
module bya_fsm
  import bya_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold_s,
  input  logic seq_boundary,
  input  logic refresh_pending,
  input  logic enhanced_mode,
  input  logic refresh_done,
  output logic hold_ack,
  output logic bus_float,
  output logic refresh_grant
);
  arb_state_t st, nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_OWN: begin
        if (seq_boundary) begin
          if (refresh_pending) nxt = ST_REFRESH;
          else if (hold_s)     nxt = ST_GRANT;
        end
      end
      ST_GRANT: begin
        if (!hold_s)                               nxt = ST_OWN;
        else if (enhanced_mode && refresh_pending) nxt = ST_RECLAIM;
      end
      ST_RECLAIM: begin
        if (!hold_s) nxt = ST_REFRESH;
      end
      ST_REFRESH: begin
        if (refresh_done) nxt = hold_s ? ST_GRANT : ST_OWN;
      end
      default: nxt = ST_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_OWN;
      hold_ack      <= 1'b0;
      bus_float     <= 1'b0;
      refresh_grant <= 1'b0;
    end else begin
      st            <= nxt;
      hold_ack      <= (nxt == ST_GRANT);
      bus_float     <= (nxt == ST_GRANT) || (nxt == ST_RECLAIM);
      refresh_grant <= (nxt == ST_REFRESH);
    end
  end
endmodule

// File: rtl/bya_addr_hold.sv
module bya_addr_hold #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         freeze,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                  q <= '0;
    else if (load && !freeze) q <= d;
  end
endmodule

// File: rtl/bus_yield_arbiter.sv
module bus_yield_arbiter #(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_req,
  input  logic              seq_boundary,
  input  logic              refresh_pending,
  input  logic              enhanced_mode,
  input  logic              refresh_done,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              hold_ack,
  output logic              bus_float,
  output logic              refresh_grant,
  output logic [ADDR_W-1:0] lat_addr_q
);
  logic hold_sync;

  bya_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (hold_req),
    .q   (hold_sync)
  );

  bya_fsm u_fsm (
    .clk             (clk),
    .rst             (rst),
    .hold_s          (hold_sync),
    .seq_boundary    (seq_boundary),
    .refresh_pending (refresh_pending),
    .enhanced_mode   (enhanced_mode),
    .refresh_done    (refresh_done),
    .hold_ack        (hold_ack),
    .bus_float       (bus_float),
    .refresh_grant   (refresh_grant)
  );

  bya_addr_hold #(.W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .load   (addr_load),
    .freeze (bus_float),
    .d      (addr_in),
    .q      (lat_addr_q)
  );
endmodule

// File: rtl/bus_yield_arbiter_chk.sv
module bus_yield_arbiter_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              hold_sync,
  input logic              seq_boundary,
  input logic              enhanced_mode,
  input logic              refresh_done,
  input logic              hold_ack,
  input logic              bus_float,
  input logic              refresh_grant,
  input logic [ADDR_W-1:0] lat_addr_q
);
  // R2
  ack_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(seq_boundary || refresh_done));

  // R3
  ack_implies_float_chk: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> bus_float);

  // R6
  refresh_not_floated_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_grant |-> !bus_float && !hold_ack);

  // R7
  compat_keeps_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!enhanced_mode && hold_ack && hold_sync) |=> hold_ack);

  // R9
  addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_float && $past(bus_float)) |-> $stable(lat_addr_q));
endmodule

bind bus_yield_arbiter bus_yield_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .hold_sync     (hold_sync),
  .seq_boundary  (seq_boundary),
  .enhanced_mode (enhanced_mode),
  .refresh_done  (refresh_done),
  .hold_ack      (hold_ack),
  .bus_float     (bus_float),
  .refresh_grant (refresh_grant),
  .lat_addr_q    (lat_addr_q)
);

// File: tb/bus_yield_arbiter_bench.sv
module bus_yield_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold_req = 1'b0, seq_boundary = 1'b0, refresh_pending = 1'b0;
  logic       enhanced_mode = 1'b0, refresh_done = 1'b0, addr_load = 1'b0;
  logic [1:0] addr_in = 2'b00;
  logic       hold_ack, bus_float, refresh_grant;
  logic [1:0] lat_addr_q;
  integer     nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  bus_yield_arbiter u_bus_yield_arbiter (
    .clk(clk), .rst(rst), .hold_req(hold_req), .seq_boundary(seq_boundary),
    .refresh_pending(refresh_pending), .enhanced_mode(enhanced_mode),
    .refresh_done(refresh_done), .addr_load(addr_load), .addr_in(addr_in),
    .hold_ack(hold_ack), .bus_float(bus_float), .refresh_grant(refresh_grant),
    .lat_addr_q(lat_addr_q)
  );

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic outs(input string tag, input logic a, input logic f, input logic g);
    chk({tag, " hold_ack"}, hold_ack, a);
    chk({tag, " bus_float"}, bus_float, f);
    chk({tag, " refresh_grant"}, refresh_grant, g);
  endtask

  task automatic settle();
    hold_req = 0; refresh_pending = 0; refresh_done = 0; seq_boundary = 1;
    step(4);
  endtask

  task automatic t_reset();
    step(3); rst = 0; step(1);
    outs("R10 reset", 0, 0, 0);
    chk("R10 latch", lat_addr_q, 0);
  endtask

  task automatic t_sync_and_release();
    seq_boundary = 1; hold_req = 1;
    step(2); outs("R1 before sync", 0, 0, 0);
    step(1); outs("R1 grant edge", 1, 1, 0);
    hold_req = 0;
    step(2); outs("R4 still held", 1, 1, 0);
    step(1); outs("R4 release", 0, 0, 0);
    settle();
  endtask

  task automatic t_boundary_only();
    seq_boundary = 0; hold_req = 1;
    for (int i = 0; i < 6; i++) begin
      step(1); outs("R2 mid cycle", 0, 0, 0);
    end
    seq_boundary = 1;
    step(1); outs("R3 together", 1, 1, 0);
    settle();
  endtask

  task automatic t_reclaim();
    enhanced_mode = 1; seq_boundary = 1; hold_req = 1;
    step(3); outs("R5 granted", 1, 1, 0);
    refresh_pending = 1;
    step(1); outs("R5 drop ack", 0, 1, 0);
    for (int i = 0; i < 5; i++) begin
      step(1); outs("R5 wait master", 0, 1, 0);
    end
    hold_req = 0;
    step(2); outs("R5 hold seen high", 0, 1, 0);
    step(1); outs("R6 refresh grant", 0, 0, 1);
    refresh_pending = 0;
    step(1); hold_req = 1;
    step(2); outs("R6 refresh running", 0, 0, 1);
    refresh_done = 1;
    step(1); outs("R6 regrant", 1, 1, 0);
    refresh_done = 0;
    for (int i = 0; i < 3; i++) begin
      step(1); outs("R6 single refresh", 1, 1, 0);
    end
    settle();
    enhanced_mode = 0;
  endtask

  task automatic t_compat();
    enhanced_mode = 0; seq_boundary = 1; hold_req = 1;
    step(3); outs("R7 granted", 1, 1, 0);
    refresh_pending = 1;
    for (int i = 0; i < 6; i++) begin
      step(1); outs("R7 ack kept", 1, 1, 0);
    end
    hold_req = 0;
    step(3); outs("R7 released", 0, 0, 0);
    step(1); outs("R7 refresh after release", 0, 0, 1);
    refresh_done = 1; refresh_pending = 0;
    step(1); outs("R7 back to own", 0, 0, 0);
    settle();
  endtask

  task automatic t_priority();
    seq_boundary = 0; hold_req = 1; refresh_pending = 1;
    step(3); outs("R8 no boundary", 0, 0, 0);
    seq_boundary = 1;
    step(1); outs("R8 refresh first", 0, 0, 1);
    refresh_pending = 0; refresh_done = 1;
    step(1); outs("R8 then hold", 1, 1, 0);
    settle();
  endtask

  task automatic t_addr();
    addr_in = 2'b01; addr_load = 1;
    step(1); chk("R9 load", lat_addr_q, 2'b01);
    addr_load = 0; hold_req = 1; seq_boundary = 1;
    step(3); chk("R9 granted", hold_ack, 1);
    addr_in = 2'b10; addr_load = 1;
    step(2); chk("R9 frozen", lat_addr_q, 2'b01);
    addr_in = 2'b11; hold_req = 0;
    step(3); chk("R9 released float", bus_float, 0);
    chk("R9 held until release", lat_addr_q, 2'b01);
    step(1); chk("R9 reload", lat_addr_q, 2'b11);
    addr_load = 0;
    settle();
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_sync_and_release();
    t_boundary_only();
    t_reclaim();
    t_compat();
    t_priority();
    t_addr();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule